// File: doc/BRIEF.md
# Four-Function Gate-Level ALU

This block is a combinational arithmetic-logic unit. It takes two 5-bit operands and a 2-bit operation code, and it drives a single 5-bit result. It computes the bitwise AND, the bitwise OR, the bitwise XOR and the modulo-32 sum of the operands. The operation code picks which of the four results appears at the output.

Every part of the block is structural, built from gate primitives and module instances:

- The adder is a ripple chain of gate-level full adders.
- The three logic functions are one gate per bit.
- The output choice is a 2-to-4 decoder followed by an AND-OR selection network.

The block has no conditional operator, no procedural datapath code, no storage and no clock. The block has no carry-out and no flags. A parent module can place it directly in a datapath and register its result at the parent's own pipeline boundary if it needs one.

Top module: `quad_op_alu`

## Requirements
- R1: With `op_sel` = 2'b00, `result` equals the bitwise AND of `opnd_a` and `opnd_b`.
- R2: With `op_sel` = 2'b01, `result` equals (`opnd_a` + `opnd_b`) mod 32. The carry out of bit 4 is discarded, and no flag is produced.
- R3: With `op_sel` = 2'b10, `result` equals the bitwise OR of the operands.
- R4: With `op_sel` = 2'b11, `result` equals the bitwise XOR of the operands.
- R5: A carry generated in bit 0 ripples through every higher bit. For example, 5'b01111 + 5'b00001 = 5'b10000, and 5'b11111 + 5'b00001 = 5'b00000.
- R6: For every value of `op_sel`, exactly one of the four decoder lines is active, so exactly one function reaches `result`.
- R7: `result` is a function of the present inputs only. A change on any input appears at `result` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 5 | First operand |
| opnd_b | input | 5 | Second operand |
| op_sel | input | 2 | Operation code: 00 AND, 01 ADD, 10 OR, 11 XOR |
| result | output | 5 | Selected function of the operands |

## Verification
Immediate assertions check the result against the operand function named by the operation code whenever an input changes. They also check that the decoder drives a one-hot set of lines, and that the adder's carry chain together with its sum bits equals the full 6-bit sum.

The bench applies every operand and operation combination, so all the carry patterns are covered. It also changes inputs between clock edges to show that the result follows the inputs with no registers in the path. Named boundary cases such as full-width wrap and all-ones operands are checked separately.

// File: rtl/quad_op_alu_pkg.sv
package quad_op_alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_ADD = 2'b01,
    OP_OR  = 2'b10,
    OP_XOR = 2'b11
  } alu_op_e;

  localparam int unsigned NUM_OPS = 4;
endpackage

// File: rtl/qa_full_adder.sv
module qa_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic prop, gen, pass;

  xor u_prop (prop, a_i, b_i);
  xor u_sum  (s_o, prop, c_i);
  and u_gen  (gen, a_i, b_i);
  and u_pass (pass, c_i, prop);
  or  u_cout (c_o, gen, pass);
endmodule

// File: rtl/qa_ripple_adder.sv
module qa_ripple_adder #(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int unsigned EXT_W = WIDTH + 1;

  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    qa_full_adder u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (carry[i]),
      .s_o (sum_o[i]),
      .c_o (carry[i+1])
    );
  end

  // R5: the chained carries plus sum bits must form the full-width sum
  always_comb begin
    a_r5_carry_chain: assert ({carry[WIDTH], sum_o} ==
                              (EXT_W'(a_i) + EXT_W'(b_i)))
      else $error("a_r5_carry_chain: carry chain mismatch");
  end
endmodule

// File: rtl/qa_logic_unit.sv
module qa_logic_unit #(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] xor_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    and u_and (and_o[i], a_i[i], b_i[i]);
    or  u_or  (or_o[i],  a_i[i], b_i[i]);
    xor u_xor (xor_o[i], a_i[i], b_i[i]);
  end
endmodule

// File: rtl/qa_select_net.sv
module qa_select_net #(
  parameter int unsigned WIDTH = 5
) (
  input  logic [1:0]       sel_i,
  input  logic [WIDTH-1:0] in0_i,
  input  logic [WIDTH-1:0] in1_i,
  input  logic [WIDTH-1:0] in2_i,
  input  logic [WIDTH-1:0] in3_i,
  output logic [WIDTH-1:0] y_o
);
  logic       s0_n, s1_n;
  logic [3:0] dec;

  not u_inv0 (s0_n, sel_i[0]);
  not u_inv1 (s1_n, sel_i[1]);
  and u_dec0 (dec[0], s1_n,     s0_n);
  and u_dec1 (dec[1], s1_n,     sel_i[0]);
  and u_dec2 (dec[2], sel_i[1], s0_n);
  and u_dec3 (dec[3], sel_i[1], sel_i[0]);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic t0, t1, t2, t3;
    and u_m0 (t0, dec[0], in0_i[i]);
    and u_m1 (t1, dec[1], in1_i[i]);
    and u_m2 (t2, dec[2], in2_i[i]);
    and u_m3 (t3, dec[3], in3_i[i]);
    or  u_mo (y_o[i], t0, t1, t2, t3);
  end

  // R6: exactly one decoder line active, and it matches the code
  always_comb begin
    a_r6_decode_onehot: assert ($countones(dec) == 1)
      else $error("a_r6_decode_onehot: decode not one-hot");
    a_r6_decode_index: assert (dec[sel_i] == 1'b1)
      else $error("a_r6_decode_index: wrong line active");
  end
endmodule

// File: rtl/quad_op_alu.sv
module quad_op_alu
  import quad_op_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] and_v, or_v, xor_v, sum_v;

  qa_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .and_o (and_v),
    .or_o  (or_v),
    .xor_o (xor_v)
  );

  qa_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .sum_o (sum_v)
  );

  qa_select_net #(.WIDTH(WIDTH)) u_select (
    .sel_i (op_sel),
    .in0_i (and_v),
    .in1_i (sum_v),
    .in2_i (or_v),
    .in3_i (xor_v),
    .y_o   (result)
  );

  // Result against the function named by the code (R1..R4)
  always_comb begin
    if (alu_op_e'(op_sel) == OP_AND) begin
      a_r1_and_result: assert (result == (opnd_a & opnd_b))
        else $error("a_r1_and_result: mismatch");
    end
    if (alu_op_e'(op_sel) == OP_ADD) begin
      a_r2_sum_wraps: assert (result == WIDTH'(opnd_a + opnd_b))
        else $error("a_r2_sum_wraps: mismatch");
    end
    if (alu_op_e'(op_sel) == OP_OR) begin
      a_r3_or_result: assert (result == (opnd_a | opnd_b))
        else $error("a_r3_or_result: mismatch");
    end
    if (alu_op_e'(op_sel) == OP_XOR) begin
      a_r4_xor_result: assert (result == (opnd_a ^ opnd_b))
        else $error("a_r4_xor_result: mismatch");
    end
  end
endmodule

// File: tb/test_quad_op_alu.sv
module test_quad_op_alu;
  localparam int unsigned W = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [1:0]   sel = 2'b00;
  logic [W-1:0] y;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          done     = 1'b0;

  always #5 clk = ~clk;

  quad_op_alu #(.WIDTH(W)) i_quad_op_alu (
    .opnd_a (a),
    .opnd_b (b),
    .op_sel (sel),
    .result (y)
  );

  function automatic logic [W-1:0] model(input int unsigned x, input int unsigned z,
                                         input int unsigned op);
    int unsigned r;
    case (op)
      0: r = x & z;
      1: r = (x + z) % 32;
      2: r = x | z;
      default: r = x ^ z;
    endcase
    return W'(r);
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_checks++;
    if (y !== exp) begin
      n_fails++;
      $display("FAIL %s: a=%0d b=%0d sel=%0d actual=%0d expected=%0d",
               req, a, b, sel, y, exp);
    end
  endtask

  task automatic apply(input int unsigned x, input int unsigned z,
                       input int unsigned op, input string req);
    @(negedge clk);
    a = W'(x); b = W'(z); sel = 2'(op);
    #2;
    check(req, model(x, z, op));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // zero inputs after reset: every function yields zero (R1 R2 R3 R4)
    apply(0, 0, 0, "R1");
    apply(0, 0, 1, "R2");
    apply(0, 0, 2, "R3");
    apply(0, 0, 3, "R4");
    // R5 ripple corner cases
    apply(15, 1, 1, "R5");
    apply(31, 1, 1, "R5");
    apply(31, 31, 1, "R2");
    apply(16, 16, 1, "R2");
    apply(31, 31, 3, "R4");
    apply(21, 10, 2, "R3");
    apply(21, 10, 0, "R1");
    // R6: every op code on the same operands picks a distinct function
    for (int op = 0; op < 4; op++) apply(22, 13, op, "R6");
    // exhaustive sweep of all codes and operands (R1..R4 by op)
    for (int op = 0; op < 4; op++)
      for (int x = 0; x < 32; x++)
        for (int z = 0; z < 32; z++)
          apply(x, z, op, op == 0 ? "R1" : op == 1 ? "R2" : op == 2 ? "R3" : "R4");
    // R7: inputs change mid-cycle with no edge, result follows at once
    @(posedge clk);
    #1 a = 5'd7; b = 5'd9; sel = 2'b01;
    #1 check("R7", 5'd16);
    #1 sel = 2'b11;
    #1 check("R7", 5'd14);
    #1 b = 5'd25;
    #1 check("R7", 5'd30);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule